// File: doc/BRIEF.md
# Dual-Triplet Lockstep Vote Logger

This block observes the data outputs of six identical processing units that leave a shared reset together and then run in lockstep. The units form two voting groups of three: group 0 holds units 0 to 2 and group 1 holds units 3 to 5. On every cycle after reset, each group takes a bitwise two-of-three majority of its members. The two voted results are also compared with each other.

The block does not pass the voted value on. It records where each disagreement happened and on which cycle. It builds a short record with the value of a free-running 32-bit cycle counter, an event kind, the group, the offending unit and a mask of the disagreeing bit lanes. Records go into a small event queue that a host drains one record at a time. Each group also has its own saturating failure counter, so a long stress run can be summarised per group without reading out every record.

A single-cycle clear input empties the queue, zeroes the failure counters and drops the overflow flag. The cycle counter keeps running through a clear, so later records stay on the same time base.

Top module: `lockstep_vote_logger`

## Requirements
- R1: `cycle_count` is 0 while reset is active and rises by exactly 1 on every clock edge out of reset. `clear` does not affect it. Every record carries the counter value of the cycle in which the offending inputs were sampled.
- R2: Unit k drives `unit_data[k*DATA_W +: DATA_W]`. Group g consists of units 3g, 3g+1 and 3g+2. When exactly one member of a group differs from the group's bitwise majority, one record is written with kind 0, that group, the unit's global index (0 to 5), and the lanes where that unit differs.
- R3: When two or more members of a group each differ from the majority on some lanes, so that no single dissenter exists, one record is written with kind 1, that group, unit field 0, and the OR of all differing lanes.
- R4: When the two voted results differ, one record is written with kind 2, group 0, unit field 0, and the XOR of the two voted values as the lane mask.
- R5: Records raised in the same cycle enter the queue in a fixed order: group 0 first, then group 1, then the between-groups record.
- R6: A group's failure counter rises by 1 in each cycle in which that group raises a kind 0 or kind 1 record. A between-groups mismatch does not change either counter.
- R7: A failure counter that has reached its all-ones value stays there and never wraps.
- R8: A record that finds the queue full is dropped, and the sticky `overflow` output goes to 1. Records of the same cycle that still fit are kept in R5 order. The failure counters keep counting while records are being dropped.
- R9: A cycle with `clear` high empties the queue, zeroes both failure counters and clears `overflow`. Anomalies sampled in that same cycle are neither recorded nor counted.
- R10: `evt_valid` is 1 exactly when the queue holds a record, and the oldest record is presented on the `evt_*` outputs. `evt_pop` with `evt_valid` high removes that record. `evt_pop` on an empty queue has no effect.
- R11: A cycle in which all six units agree writes no record and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, released together with the units' reset |
| clear | input | 1 | One-cycle clear of the queue, counters and overflow flag |
| unit_data | input | 6*DATA_W | Output buses of the six units, unit k at bits k*DATA_W upward |
| evt_pop | input | 1 | Remove the record at the head of the queue |
| evt_valid | output | 1 | The queue holds at least one record |
| evt_cycle | output | 32 | Cycle number of the head record |
| evt_kind | output | 2 | 0 single dissenter, 1 no single dissenter, 2 groups differ |
| evt_group | output | 1 | Group of the head record |
| evt_unit | output | 3 | Global index of the dissenting unit (kind 0), else 0 |
| evt_lanes | output | DATA_W | Mask of the disagreeing bit lanes |
| overflow | output | 1 | Sticky flag: at least one record was dropped |
| fail_cnt0 | output | CNT_W | Saturating failure count of group 0 |
| fail_cnt1 | output | CNT_W | Saturating failure count of group 1 |
| cycle_count | output | 32 | Free-running compared-cycle counter |

## Verification
Three records can be raised in one cycle: a dissenter in each group, with the two voted values also disagreeing. That same cycle can also find the queue almost full. The bench drives one input word that causes all three anomalies together. It first checks that they are queued in the fixed order, each with its own lane mask. It then repeats the word with seven records already queued, and checks that only the group 0 record is kept, that the flag turns sticky, and that both counters still step. A second case puts `clear` in the same cycle as an anomaly and checks that the clear wins.

// File: rtl/lvl_pkg.sv
// Package: shared constants and event kinds of the lockstep vote logger.
// Assumes two voting groups of three units each and a 32-bit time base.
package lvl_pkg;
    localparam int GROUPS          = 2;
    localparam int UNITS_PER_GROUP = 3;
    localparam int UNITS           = GROUPS * UNITS_PER_GROUP;
    localparam int EVT_SOURCES     = GROUPS + 1;
    localparam int CYC_W           = 32;
    localparam int KIND_W          = 2;
    localparam int UNIT_W          = 3;

    typedef enum logic [KIND_W-1:0] {
        EV_SINGLE = 2'd0,
        EV_SPLIT  = 2'd1,
        EV_CROSS  = 2'd2
    } ev_kind_e;
endpackage

// File: rtl/triplet_voter.sv
// Module: triplet_voter
// Bitwise two-of-three majority over one group of units. It reports whether
// exactly one member disagrees (and which one), or whether several members
// disagree on different lanes. Purely combinational. Assumes the three member
// buses are packed as member 0 at the low end.
module triplet_voter #(
    parameter int W     = 8,
    parameter int GROUP = 0
) (
    input  logic [3*W-1:0] members,
    output logic [W-1:0]   voted,
    output logic           single,
    output logic           split,
    output logic [2:0]     unit_idx,
    output logic [W-1:0]   lanes
);
    logic [W-1:0] m0, m1, m2;
    logic [W-1:0] d0, d1, d2;
    logic [2:0]   dis;

    // Majority and per-member difference masks.
    always_comb begin
        m0    = members[0*W +: W];
        m1    = members[1*W +: W];
        m2    = members[2*W +: W];
        voted = (m0 & m1) | (m0 & m2) | (m1 & m2);
        d0    = m0 ^ voted;
        d1    = m1 ^ voted;
        d2    = m2 ^ voted;
        dis   = {|d2, |d1, |d0};
        lanes = d0 | d1 | d2;
    end

    // Classify the disagreement and locate a lone dissenter.
    always_comb begin
        single   = ($countones(dis) == 1);
        split    = ($countones(dis) > 1);
        unit_idx = 3'(GROUP * 3);
        if (single) begin
            case (dis)
                3'b010:  unit_idx = 3'(GROUP * 3 + 1);
                3'b100:  unit_idx = 3'(GROUP * 3 + 2);
                default: unit_idx = 3'(GROUP * 3);
            endcase
        end
    end
endmodule

// File: rtl/event_fifo.sv
// Module: event_fifo
// Multi-push, single-pop record queue. Up to NPUSH records per cycle enter in
// index order as long as space remains; the rest are reported as dropped.
// Assumes DEPTH is a power of two. Space is judged before any same-cycle pop.
module event_fifo #(
    parameter int REC_W = 46,
    parameter int DEPTH = 8,
    parameter int NPUSH = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [NPUSH-1:0]       push_req,
    input  logic [NPUSH*REC_W-1:0] push_data,
    input  logic                   pop,
    output logic [REC_W-1:0]       head,
    output logic                   valid,
    output logic                   dropped
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [REC_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count, free, taken;
    logic [NPUSH-1:0] we;
    logic [AW-1:0]    slot [NPUSH];
    logic             do_pop;

    // Grant pushes in order while free slots remain.
    always_comb begin
        free  = CW'(DEPTH) - count;
        taken = '0;
        for (int k = 0; k < NPUSH; k++) begin
            we[k]   = 1'b0;
            slot[k] = wptr + AW'(taken);
            if (push_req[k] && !flush && (taken < free)) begin
                we[k] = 1'b1;
                taken = taken + 1'b1;
            end
        end
        dropped = !flush && |(push_req & ~we);
        do_pop  = pop && (count != '0) && !flush;
        valid   = (count != '0);
        head    = mem[rptr];
    end

    // Store the granted records.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NPUSH; k++) begin
            if (we[k]) mem[slot[k]] <= push_data[k*REC_W +: REC_W];
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + AW'(taken);
            rptr  <= rptr + AW'(do_pop);
            count <= count + taken - CW'(do_pop);
        end
    end

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !valid);
    a_r10_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && push_req == '0 && !flush) |=> !valid);
endmodule

// File: rtl/sat_counter.sv
// Module: sat_counter
// Failure counter that steps by one per request and holds at all-ones.
// Assumes clr has priority over inc.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              value <= '0;
        else if (inc && (value != '1)) value <= value + 1'b1;
    end

    a_r6_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> value >= $past(value));
    a_r7_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && value == '1) |=> value == '1);
endmodule

// File: rtl/lockstep_vote_logger.sv
// Module: lockstep_vote_logger
// Votes two groups of three lockstep units, compares the group results,
// turns every anomaly into a timestamped location record, queues the
// records, and keeps per-group saturating failure counts. Assumes rst_n is
// released in the same cycle as the units' own reset.
module lockstep_vote_logger #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [6*DATA_W-1:0]   unit_data,
    input  logic                  evt_pop,
    output logic                  evt_valid,
    output logic [31:0]           evt_cycle,
    output logic [1:0]            evt_kind,
    output logic                  evt_group,
    output logic [2:0]            evt_unit,
    output logic [DATA_W-1:0]     evt_lanes,
    output logic                  overflow,
    output logic [CNT_W-1:0]      fail_cnt0,
    output logic [CNT_W-1:0]      fail_cnt1,
    output logic [31:0]           cycle_count
);
    import lvl_pkg::*;

    localparam int REC_W = CYC_W + KIND_W + 1 + UNIT_W + DATA_W;
    localparam int GW    = UNITS_PER_GROUP * DATA_W;

    logic [DATA_W-1:0]            voted  [GROUPS];
    logic [GROUPS-1:0]            single, split, anomaly;
    logic [2:0]                   uidx   [GROUPS];
    logic [DATA_W-1:0]            glanes [GROUPS];
    logic [EVT_SOURCES-1:0]       req;
    logic [EVT_SOURCES*REC_W-1:0] recs;
    logic [DATA_W-1:0]            xlanes;
    logic [REC_W-1:0]             head;
    logic                         dropped;
    logic [CNT_W-1:0]             cnt [GROUPS];

    // Free-running time base, untouched by clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cycle_count <= '0;
        else        cycle_count <= cycle_count + 1'b1;
    end

    // One voter and one failure counter per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        triplet_voter #(.W(DATA_W), .GROUP(g)) u_vote (
            .members  (unit_data[g*GW +: GW]),
            .voted    (voted[g]),
            .single   (single[g]),
            .split    (split[g]),
            .unit_idx (uidx[g]),
            .lanes    (glanes[g])
        );
        assign anomaly[g] = single[g] | split[g];

        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .inc   (anomaly[g]),
            .value (cnt[g])
        );
    end

    assign fail_cnt0 = cnt[0];
    assign fail_cnt1 = cnt[1];

    // Assemble the group records and the between-groups record.
    always_comb begin
        xlanes = voted[0] ^ voted[1];
        for (int g = 0; g < GROUPS; g++) begin
            req[g] = anomaly[g] && !clear;
            recs[g*REC_W +: REC_W] = {cycle_count,
                                      single[g] ? EV_SINGLE : EV_SPLIT,
                                      1'(g),
                                      single[g] ? uidx[g] : 3'd0,
                                      glanes[g]};
        end
        req[GROUPS] = (xlanes != '0) && !clear;
        recs[GROUPS*REC_W +: REC_W] = {cycle_count, EV_CROSS, 1'b0, 3'd0, xlanes};
    end

    event_fifo #(.REC_W(REC_W), .DEPTH(FIFO_DEPTH), .NPUSH(EVT_SOURCES)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (clear),
        .push_req  (req),
        .push_data (recs),
        .pop       (evt_pop),
        .head      (head),
        .valid     (evt_valid),
        .dropped   (dropped)
    );

    assign {evt_cycle, evt_kind, evt_group, evt_unit, evt_lanes} = head;

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) overflow <= 1'b0;
        else if (dropped)    overflow <= 1'b1;
    end

    a_r1_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_count == $past(cycle_count) + 32'd1);
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fail_cnt0 == '0 && fail_cnt1 == '0 && !overflow));
    a_r11_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (anomaly == '0 && !clear) |=> (fail_cnt0 == $past(fail_cnt0)
                                      && fail_cnt1 == $past(fail_cnt1)));
endmodule

// File: tb/lockstep_vote_logger_test.sv
module lockstep_vote_logger_test;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clear = 1'b0;
    logic [6*W-1:0] unit_data;
    logic           evt_pop = 1'b0;
    logic           evt_valid;
    logic [31:0]    evt_cycle;
    logic [1:0]     evt_kind;
    logic           evt_group;
    logic [2:0]     evt_unit;
    logic [W-1:0]   evt_lanes;
    logic           overflow;
    logic [3:0]     fail_cnt0, fail_cnt1;
    logic [31:0]    cycle_count;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mcyc = 0;
    logic [31:0] exp_cyc;

    localparam logic [W-1:0] BASE = 8'hA5;

    lockstep_vote_logger #(.DATA_W(W), .FIFO_DEPTH(8), .CNT_W(4)) uut (.*);

    always #4 clk = ~clk;

    // Bench time base model.
    always @(posedge clk) mcyc <= rst_n ? mcyc + 1 : 32'd0;

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6*W-1:0] all_same(logic [W-1:0] v);
        return {6{v}};
    endfunction

    // Drive one cycle of data, then return to agreement.
    task automatic apply(logic [6*W-1:0] d);
        unit_data = d;
        exp_cyc = mcyc;
        @(negedge clk);
        unit_data = all_same(BASE);
    endtask

    task automatic pop_one();
        evt_pop = 1'b1;
        @(negedge clk);
        evt_pop = 1'b0;
    endtask

    task automatic check_head(string req, logic [1:0] k, logic g, logic [2:0] u,
                              logic [W-1:0] l, logic [31:0] c);
        check({req, " valid"}, evt_valid, 1);
        check({req, " kind"},  evt_kind, k);
        check({req, " group"}, evt_group, g);
        check({req, " unit"},  evt_unit, u);
        check({req, " lanes"}, evt_lanes, l);
        check({req, " cycle"}, evt_cycle, c);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Word raising a dissenter in each group plus a group mismatch.
    function automatic logic [6*W-1:0] triple_word();
        logic [6*W-1:0] d;
        d = {8'hE3, 8'hC3, 8'hC3, 8'h3C, 8'h3D, 8'h3C};
        return d;
    endfunction

    task automatic t_reset();
        check("R1 reset cycle", cycle_count, 0);
        check("R10 reset empty", evt_valid, 0);
        check("R8 reset overflow", overflow, 0);
        check("R6 reset cnt0", fail_cnt0, 0);
        check("R6 reset cnt1", fail_cnt1, 0);
    endtask

    task automatic t_quiet();
        logic [31:0] c0;
        c0 = cycle_count;
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R1 step", cycle_count, c0 + 5);
        check("R1 model", cycle_count, mcyc);
        check("R11 no record", evt_valid, 0);
        check("R11 cnt0", fail_cnt0, 0);
        check("R11 cnt1", fail_cnt1, 0);
    endtask

    task automatic t_single();
        logic [6*W-1:0] d;
        d = all_same(BASE);
        d[4*W +: W] = BASE ^ 8'h05;
        apply(d);
        check_head("R2 single", 2'd0, 1'b1, 3'd4, 8'h05, exp_cyc);
        check("R6 single cnt1", fail_cnt1, 1);
        check("R6 single cnt0", fail_cnt0, 0);
        pop_one();
        check("R10 pop empties", evt_valid, 0);
    endtask

    task automatic t_split();
        logic [6*W-1:0] d;
        d = all_same(BASE);
        d[0*W +: W] = BASE ^ 8'h01;
        d[1*W +: W] = BASE ^ 8'h02;
        apply(d);
        check_head("R3 split", 2'd1, 1'b0, 3'd0, 8'h03, exp_cyc);
        check("R6 split cnt0", fail_cnt0, 1);
        pop_one();
        check("R3 one record", evt_valid, 0);
    endtask

    task automatic t_cross();
        apply({{3{8'h5A}}, {3{BASE}}});
        check_head("R4 cross", 2'd2, 1'b0, 3'd0, 8'hFF, exp_cyc);
        check("R6 cross cnt0", fail_cnt0, 1);
        check("R6 cross cnt1", fail_cnt1, 1);
        pop_one();
        check("R4 one record", evt_valid, 0);
    endtask

    task automatic t_order();
        logic [31:0] c;
        apply(triple_word());
        c = exp_cyc;
        check_head("R5 first", 2'd0, 1'b0, 3'd1, 8'h01, c);
        pop_one();
        check_head("R5 second", 2'd0, 1'b1, 3'd5, 8'h20, c);
        pop_one();
        check_head("R5 third", 2'd2, 1'b0, 3'd0, 8'hFF, c);
        pop_one();
        check("R5 drained", evt_valid, 0);
        check("R6 both cnt0", fail_cnt0, 2);
        check("R6 both cnt1", fail_cnt1, 2);
    endtask

    task automatic t_pop_empty();
        logic [6*W-1:0] d;
        pop_one();
        check("R10 pop empty", evt_valid, 0);
        d = all_same(BASE);
        d[2*W +: W] = BASE ^ 8'h80;
        apply(d);
        check_head("R10 after empty pop", 2'd0, 1'b0, 3'd2, 8'h80, exp_cyc);
        pop_one();
    endtask

    task automatic t_overflow();
        logic [6*W-1:0] d;
        logic [31:0] c0;
        do_clear();
        check("R9 cleared cnt0", fail_cnt0, 0);
        d = all_same(BASE);
        d[0*W +: W] = BASE ^ 8'h10;
        for (int i = 0; i < 7; i++) begin
            apply(d);
            if (i == 0) c0 = exp_cyc;
        end
        check("R8 no overflow yet", overflow, 0);
        apply(triple_word());
        check("R8 overflow set", overflow, 1);
        check("R8 cnt0 counts", fail_cnt0, 8);
        check("R8 cnt1 counts", fail_cnt1, 1);
        check_head("R8 oldest kept", 2'd0, 1'b0, 3'd0, 8'h10, c0);
        for (int i = 0; i < 7; i++) pop_one();
        check_head("R8 partial accept", 2'd0, 1'b0, 3'd1, 8'h01, exp_cyc);
        pop_one();
        check("R8 rest dropped", evt_valid, 0);
        @(negedge clk);
        check("R8 sticky", overflow, 1);
    endtask

    task automatic t_clear_same_cycle();
        logic [31:0] c;
        logic [6*W-1:0] d;
        d = all_same(BASE);
        d[3*W +: W] = BASE ^ 8'h40;
        apply(d);
        c = cycle_count;
        clear = 1'b1;
        apply(d);
        clear = 1'b0;
        check("R9 queue empty", evt_valid, 0);
        check("R9 overflow cleared", overflow, 0);
        check("R9 cnt1 zero", fail_cnt1, 0);
        check("R9 cnt0 zero", fail_cnt0, 0);
        check("R1 clear keeps cycle", cycle_count, c + 1);
    endtask

    task automatic t_saturate();
        logic [6*W-1:0] d;
        d = all_same(BASE);
        d[1*W +: W] = BASE ^ 8'h08;
        for (int i = 0; i < 20; i++) apply(d);
        check("R7 saturate cnt0", fail_cnt0, 15);
        check("R7 other cnt1", fail_cnt1, 0);
        apply(d);
        check("R7 stays max", fail_cnt0, 15);
        do_clear();
    endtask

    initial begin
        unit_data = all_same(BASE);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_quiet();
        t_single();
        t_split();
        t_cross();
        t_order();
        t_pop_empty();
        t_overflow();
        t_clear_same_cycle();
        t_saturate();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule